// File: doc/BRIEF.md
# Decimal Running-Total Accumulator with Locking Range Error

This block keeps a two-digit decimal total in packed BCD form (tens digit in bits 7:4, units digit in bits 3:0) and updates it from a stream of single decimal digits. Each digit arrives on a valid/ready handshake together with a direction bit. The digit is added to the total, or taken away from it, using per-digit decimal correction, so the output port always carries a legal two-digit decimal value that can drive a display directly.

When a transfer would carry the total past 99 or take it below 00, the block does not wrap. It shows the error code EE on the output, raises an error flag and plays one fixed burst of square-wave pulses on an alarm pin. While the error holds, the input stream is refused. Only a reset clears the error.

The stream rules are as follows. A transfer takes place on a rising clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high whenever no error is latched and low once one is. A source that sees `in_ready` low must hold its digit. The handshake never loses a transfer. A locked block simply stops accepting.

Top module: `bcd_running_total`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `total_o` is 8'h00, `err_o` is 0, `tone_o` is 0 and `in_ready` is 1.
- R2: On a transfer with `in_sub`=0 and `in_digit` in 0..9, `total_o` becomes the decimal sum of the old total and the digit from the next cycle onward. The units digit is corrected when it exceeds 9, and the carry passes into the tens digit (for example 09+1 gives 10, and adding 9 eleven times from 00 gives 09, 18, ... 90, 99).
- R3: On a transfer with `in_sub`=1 and `in_digit` in 0..9, `total_o` becomes the decimal difference. A borrow out of the units digit is taken from the tens digit (for example 10-1 gives 09).
- R4: On a cycle without a transfer, `total_o` does not change. A transfer whose digit is 10..15 completes the handshake but leaves `total_o` unchanged.
- R5: A transfer whose sum exceeds 99 sets `err_o` to 1 and `total_o` to 8'hEE from the next cycle onward.
- R6: A transfer whose difference is below 00 has the same effect as R5: `err_o` is 1 and `total_o` is 8'hEE.
- R7: `tone_o` goes high in the same cycle as `err_o` and stays high for TONE_HALF cycles. It then alternates every TONE_HALF cycles until exactly TONE_PULSES high pulses (255 by default) have been produced, after which it stays low. `tone_o` is 0 whenever no error is latched.
- R8: Once an error is latched, `in_ready` is 0. `err_o` stays 1 and `total_o` stays 8'hEE whatever the inputs do, until reset. After a reset the block counts again from 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source offers a digit |
| in_ready | output | 1 | Block accepts a digit (low while locked) |
| in_digit | input | 4 | Decimal digit; codes 10..15 are discarded |
| in_sub | input | 1 | 0 adds the digit, 1 subtracts it |
| total_o | output | 8 | Packed BCD total, tens in 7:4, units in 3:0; 8'hEE on error |
| err_o | output | 1 | Range error latched |
| tone_o | output | 1 | Alarm square-wave burst |

## Verification
The hardest state to reach from the ports is overflow. It needs the total built up to 99 through eleven accepted transfers, and only then can one more digit tip it over. The vector table walks that climb, and the directed test repeats it before pushing the extra digit. The alarm burst that follows lasts about two thousand cycles. The bench counts its rising edges and measures the width of the first pulse while it keeps offering digits, which shows that the locked block ignores them. Underflow is reached directly from 00, and the digit-boundary carry and borrow (09+1, 10-1) are driven on purpose.

// File: rtl/bcd_acc_pkg.sv
package bcd_acc_pkg;
  localparam int DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] bcd_t;
  localparam bcd_t ERR_DIGIT = 4'hE;
  localparam bcd_t MAX_DIGIT = 4'd9;

  function automatic logic digit_legal(input bcd_t d);
    return d <= MAX_DIGIT;
  endfunction
endpackage

// File: rtl/bcd_digit_unit.sv
module bcd_digit_unit
  import bcd_acc_pkg::*;
(
  input  bcd_t a_i,
  input  bcd_t b_i,
  input  logic cy_i,
  input  logic sub_i,
  output bcd_t s_o,
  output logic cy_o
);
  logic [4:0] raw_add;
  logic [4:0] need;

  always_comb begin
    raw_add = {1'b0, a_i} + {1'b0, b_i} + {4'd0, cy_i};
    need    = {1'b0, b_i} + {4'd0, cy_i};
    if (!sub_i) begin
      if (raw_add > 5'd9) begin
        s_o  = bcd_t'(raw_add - 5'd10);
        cy_o = 1'b1;
      end else begin
        s_o  = raw_add[3:0];
        cy_o = 1'b0;
      end
    end else begin
      if ({1'b0, a_i} < need) begin
        s_o  = bcd_t'({1'b0, a_i} + 5'd10 - need);
        cy_o = 1'b1;
      end else begin
        s_o  = bcd_t'({1'b0, a_i} - need);
        cy_o = 1'b0;
      end
    end
  end
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain
  import bcd_acc_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic [DIGITS*DIGIT_W-1:0] acc_i,
  input  bcd_t                      digit_i,
  input  logic                      sub_i,
  output logic [DIGITS*DIGIT_W-1:0] res_o,
  output logic                      out_of_range_o
);
  logic [DIGITS:0] cy;
  assign cy[0] = 1'b0;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    bcd_t operand;
    if (g == 0) begin : g_low
      assign operand = digit_i;
    end else begin : g_high
      assign operand = '0;
    end
    bcd_digit_unit u_unit (
      .a_i  (acc_i[g*DIGIT_W +: DIGIT_W]),
      .b_i  (operand),
      .cy_i (cy[g]),
      .sub_i(sub_i),
      .s_o  (res_o[g*DIGIT_W +: DIGIT_W]),
      .cy_o (cy[g+1])
    );
  end

  assign out_of_range_o = cy[DIGITS];
endmodule

// File: rtl/bcd_alarm.sv
module bcd_alarm #(
  parameter int TONE_HALF   = 4,
  parameter int TONE_PULSES = 255
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic tone_o,
  output logic done_o
);
  localparam int HW = $clog2(TONE_HALF + 1);
  localparam int PW = $clog2(TONE_PULSES + 1);
  localparam logic [HW-1:0] HALF_LAST  = HW'(TONE_HALF - 1);
  localparam logic [PW-1:0] PULSE_LAST = PW'(TONE_PULSES - 1);

  logic          active;
  logic [HW-1:0] div_cnt;
  logic [PW-1:0] pulse_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= 1'b0;
      tone_o    <= 1'b0;
      done_o    <= 1'b0;
      div_cnt   <= '0;
      pulse_cnt <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        active    <= 1'b1;
        tone_o    <= 1'b1;
        div_cnt   <= '0;
        pulse_cnt <= '0;
      end else if (active) begin
        if (div_cnt == HALF_LAST) begin
          div_cnt <= '0;
          tone_o  <= ~tone_o;
          if (tone_o) begin
            if (pulse_cnt == PULSE_LAST) begin
              active <= 1'b0;
              done_o <= 1'b1;
            end
            pulse_cnt <= pulse_cnt + 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcd_running_total.sv
module bcd_running_total
  import bcd_acc_pkg::*;
#(
  parameter int DIGITS      = 2,
  parameter int TONE_HALF   = 4,
  parameter int TONE_PULSES = 255
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DIGIT_W-1:0]        in_digit,
  input  logic                      in_sub,
  output logic [DIGITS*DIGIT_W-1:0] total_o,
  output logic                      err_o,
  output logic                      tone_o
);
  localparam int TW = DIGITS * DIGIT_W;

  logic [TW-1:0] sum_q;
  logic [TW-1:0] sum_next;
  logic [TW-1:0] err_code;
  logic          range_hit;
  logic          take;
  logic          apply;
  logic          fault;
  logic          err_q;
  logic          burst_done;

  for (genvar g = 0; g < DIGITS; g++) begin : g_code
    assign err_code[g*DIGIT_W +: DIGIT_W] = ERR_DIGIT;
  end

  bcd_chain #(.DIGITS(DIGITS)) u_chain (
    .acc_i         (sum_q),
    .digit_i       (in_digit),
    .sub_i         (in_sub),
    .res_o         (sum_next),
    .out_of_range_o(range_hit)
  );

  assign in_ready = ~err_q;
  assign take     = in_valid & in_ready;
  assign apply    = take & digit_legal(in_digit);
  assign fault    = apply & range_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (fault) begin
        err_q <= 1'b1;
      end
      if (apply && !range_hit) begin
        sum_q <= sum_next;
      end else if (burst_done) begin
        sum_q <= '0;
      end
    end
  end

  bcd_alarm #(.TONE_HALF(TONE_HALF), .TONE_PULSES(TONE_PULSES)) u_alarm (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(fault),
    .tone_o (tone_o),
    .done_o (burst_done)
  );

  assign err_o   = err_q;
  assign total_o = err_q ? err_code : sum_q;
endmodule

// File: rtl/bcd_running_total_chk.sv
module bcd_running_total_chk #(
  parameter int DIGITS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_ready,
  input logic [3:0]            in_digit,
  input logic [DIGITS*4-1:0]   total_o,
  input logic                  err_o,
  input logic                  tone_o
);
  // R1: reset drives the idle state
  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (total_o == '0 && !err_o && !tone_o && in_ready));

  // R4: no transfer, no change
  assert_hold_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> $stable(total_o));

  // R4: illegal digit codes are discarded
  assert_drop_bad_digit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_digit > 4'd9) |=> $stable(total_o));

  // R5: error shows the EE code
  assert_err_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (total_o == {DIGITS{4'hE}}));

  // R8: error is sticky and blocks the stream
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> err_o);
  assert_locked_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !in_ready);

  // R7: tone silent without error
  assert_tone_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !err_o |-> !tone_o);

  // R2: every digit is decimal while counting
  for (genvar g = 0; g < DIGITS; g++) begin : g_legal
    assert_digit_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !err_o |-> (total_o[g*4 +: 4] <= 4'd9));
  end
endmodule

bind bcd_running_total bcd_running_total_chk #(.DIGITS(DIGITS)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .in_valid(in_valid),
  .in_ready(in_ready),
  .in_digit(in_digit),
  .total_o (total_o),
  .err_o   (err_o),
  .tone_o  (tone_o)
);

// File: tb/tb_bcd_running_total.sv
module tb_bcd_running_total;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int PULSES     = 255;
  localparam int NVEC       = 22;

  // {sub, digit, expected total}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 4'd9, 8'h09}, {1'b0, 4'd9, 8'h18}, {1'b0, 4'd9, 8'h27},
    {1'b0, 4'd9, 8'h36}, {1'b0, 4'd9, 8'h45}, {1'b0, 4'd9, 8'h54},
    {1'b0, 4'd9, 8'h63}, {1'b0, 4'd9, 8'h72}, {1'b0, 4'd9, 8'h81},
    {1'b0, 4'd9, 8'h90}, {1'b0, 4'd9, 8'h99}, {1'b1, 4'd9, 8'h90},
    {1'b1, 4'd5, 8'h85}, {1'b0, 4'd7, 8'h92}, {1'b1, 4'd3, 8'h89},
    {1'b1, 4'd9, 8'h80}, {1'b0, 4'd0, 8'h80}, {1'b0, 4'd12, 8'h80},
    {1'b1, 4'd1, 8'h79}, {1'b1, 4'd8, 8'h71}, {1'b0, 4'd9, 8'h80},
    {1'b1, 4'd0, 8'h80}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_digit = '0;
  logic       in_sub = 1'b0;
  logic [7:0] total_o;
  logic       err_o;
  logic       tone_o;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_running_total #(.DIGITS(2), .TONE_HALF(HALF), .TONE_PULSES(PULSES)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_digit(in_digit), .in_sub(in_sub), .total_o(total_o),
    .err_o(err_o), .tone_o(tone_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic push(input logic sub, input logic [3:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_digit = d;
    in_sub   = sub;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    int high_run;
    int rises;
    logic prev;
    bit  first_done;

    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R1 total in reset", total_o, 8'h00);
    check("R1 err in reset", err_o, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 total after reset", total_o, 8'h00);
    check("R1 flags after reset", {err_o, tone_o, in_ready}, 3'b001);

    for (int i = 0; i < NVEC; i++) begin
      push(VEC[i][12], VEC[i][11:8]);
      if (VEC[i][11:8] > 4'd9)
        check("R4 bad digit dropped", total_o, VEC[i][7:0]);
      else if (VEC[i][12])
        check("R3 decimal subtract", total_o, VEC[i][7:0]);
      else
        check("R2 decimal add", total_o, VEC[i][7:0]);
    end

    // R4: data without valid changes nothing
    @(negedge clk);
    in_digit = 4'd5;
    repeat (3) @(negedge clk);
    check("R4 idle hold", total_o, 8'h80);

    // R2/R3: digit boundary carry and borrow
    do_reset();
    repeat (10) push(1'b0, 4'd1);
    check("R2 carry 09+1", total_o, 8'h10);
    push(1'b1, 4'd1);
    check("R3 borrow 10-1", total_o, 8'h09);

    // R6: underflow from 00
    do_reset();
    push(1'b1, 4'd1);
    check("R6 underflow code", total_o, 8'hEE);
    check("R6 underflow flag", err_o, 1'b1);

    // R5: overflow from 99
    do_reset();
    repeat (11) push(1'b0, 4'd9);
    check("R5 reached 99", total_o, 8'h99);
    push(1'b0, 4'd1);
    check("R5 overflow code", total_o, 8'hEE);
    check("R5 overflow flag", err_o, 1'b1);
    check("R7 tone starts with error", tone_o, 1'b1);
    check("R8 not ready when locked", in_ready, 1'b0);

    // R7/R8: count the burst while offering digits
    in_valid = 1'b1;
    in_digit = 4'd3;
    in_sub   = 1'b1;
    prev = 1'b1;
    rises = 1;
    high_run = 0;
    first_done = 1'b0;
    for (int c = 0; c < PULSES * 2 * HALF + 40; c++) begin
      if (!first_done) begin
        if (tone_o) high_run++;
        else first_done = 1'b1;
      end
      if (tone_o && !prev) rises++;
      prev = tone_o;
      @(negedge clk);
    end
    in_valid = 1'b0;
    check("R7 first pulse width", high_run, HALF);
    check("R7 pulse count", rises, PULSES);
    check("R7 tone low after burst", tone_o, 1'b0);
    check("R8 total still EE", total_o, 8'hEE);
    check("R8 error still set", err_o, 1'b1);

    do_reset();
    @(negedge clk);
    check("R8 reset clears lock", {total_o, err_o, in_ready}, {8'h00, 1'b0, 1'b1});
    push(1'b0, 4'd4);
    check("R8 counting resumes", total_o, 8'h04);

    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      finished = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule